// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Manager

This block keeps an SDRAM array refreshed without help from the memory controller's main sequencer. A free-running interval timer produces one refresh credit per interval. Credits accumulate in a small saturating counter. While the block is idle and holds at least one credit, it raises a request toward the command arbiter. A single grant lets the block issue a REFRESH command for every credit it holds, one after another. After each REFRESH it holds the bus for the row cycle time before it releases the bus or issues the next one.

The block also moves the array into and out of self-refresh. A held sleep request is taken once the block is idle and the controller reports all banks precharged. The block then issues the self-refresh entry command in the same cycle that it drops the clock enable. A wake request raises the clock enable again. The block then stays busy long enough to cover three things: the one-clock module register, the device starting its exit on the second rising edge after the clock enable returns, and a full row cycle. The interval is chosen by row count at elaboration: 1560 clocks for 4k-row arrays and 780 clocks for 8k-row arrays, at 100 MHz. The row cycle is 7 clocks for the standard grade and 8 clocks for the slow grade.

Top module: `sdram_refresh_mgr`

## Requirements
- R1: After reset, cke is 1, busy, ref_req and in_self_refresh are 0, mem_cmd is NOP (2'b00) and pend_cnt is 0.
- R2: pend_cnt gains one credit every INT_4K clocks when ROWS_8K is 0, and every INT_8K clocks when ROWS_8K is 1.
- R3: ref_req is high exactly when the block is idle with pend_cnt non-zero. It stays high until ref_ack is sampled high, and busy is never high at the same time.
- R4: The cycle after ref_ack is sampled with ref_req high, mem_cmd is REFRESH (2'b01) and busy is high. Then follow TRC NOP cycles with busy high, where TRC is TRC_FAST or TRC_SLOW as selected by SLOW_GRADE.
- R5: pend_cnt saturates at MAX_PEND (8) when credits are not serviced.
- R6: One grant drains every held credit: REFRESH commands repeat every TRC+1 cycles with busy held high, and no further ref_ack is needed.
- R7: When an interval credit arrives on the same clock edge that ends a REFRESH cycle, pend_cnt keeps its value.
- R8: sleep_req is accepted only when idle with banks_idle high, and is otherwise held pending. On acceptance, mem_cmd is SELF_ENTER (2'b10), and in that same cycle cke is 0 and in_self_refresh is 1.
- R9: If sleep is accepted on the same edge as ref_ack, self-refresh entry wins: no REFRESH is issued and pend_cnt clears to 0.
- R10: In self-refresh, cke stays 0, mem_cmd stays NOP, interval credits are discarded, ref_req stays 0, and ref_ack and sleep_req have no effect.
- R11: A wake_req sampled in self-refresh raises cke in the next cycle. busy is then high with NOP for TRC+REG_LAT+2 cycles (11 with the slow grade), after which the block is idle. wake_req outside self-refresh has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ack | input | 1 | Arbiter grant for the refresh request |
| sleep_req | input | 1 | Level request to enter self-refresh |
| banks_idle | input | 1 | All banks are precharged |
| wake_req | input | 1 | Request to leave self-refresh |
| ref_req | output | 1 | Refresh request to the arbiter |
| busy | output | 1 | Refresh or exit wait in progress |
| cke | output | 1 | Clock enable toward the array |
| mem_cmd | output | 2 | Command: 00 NOP, 01 REFRESH, 10 SELF_ENTER |
| in_self_refresh | output | 1 | Array is in self-refresh |
| pend_cnt | output | PW | Held refresh credits |

## Verification
Two pairs of functions can meet in one cycle, and each is checked. The first pair is an interval credit landing on the same edge that consumes a credit for a REFRESH. The bench learns the credit phase by watching pend_cnt step, then places the grant so that the REFRESH cycle ends exactly on the next credit edge. It then expects pend_cnt unchanged, not one higher or one lower. The second pair is a grant arriving together with an acceptable sleep request. The bench drives both on the same edge and expects SELF_ENTER rather than REFRESH, with the credits cleared on the following cycle.

// File: rtl/rfm_pkg.sv
package rfm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_REF    = 3'd1,
    ST_RWAIT  = 3'd2,
    ST_SENTER = 3'd3,
    ST_SR     = 3'd4,
    ST_EXIT   = 3'd5
  } seq_state_t;

  typedef enum logic [1:0] {
    CMD_NOP      = 2'b00,
    CMD_REFRESH  = 2'b01,
    CMD_SR_ENTER = 2'b10
  } mem_cmd_t;

endpackage

// File: rtl/rfm_interval_timer.sv
module rfm_interval_timer #(
  parameter int INT_4K  = 1560,
  parameter int INT_8K  = 780,
  parameter bit ROWS_8K = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int INTERVAL = ROWS_8K ? INT_8K : INT_4K;
  localparam int CW       = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    tick  = (cnt_q == '0);
    cnt_d = tick ? RELOAD : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rfm_pending_ctr.sv
module rfm_pending_ctr #(
  parameter int MAX_PEND = 8,
  parameter int PW       = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic          clr,
  output logic [PW-1:0] count,
  output logic          nonzero
);

  localparam logic [PW-1:0] CAP = PW'(MAX_PEND);

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (inc && !dec && (cnt_q != CAP)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end else if (dec && !inc && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count   = cnt_q;
  assign nonzero = (cnt_q != '0);

endmodule

// File: rtl/rfm_sequencer.sv
module rfm_sequencer
  import rfm_pkg::*;
#(
  parameter int TRC      = 7,
  parameter int EXIT_CYC = 10
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pend_nz,
  input  logic     ref_ack,
  input  logic     sleep_req,
  input  logic     banks_idle,
  input  logic     wake_req,
  output logic     ref_req,
  output logic     busy,
  output logic     cke,
  output logic     in_sr,
  output mem_cmd_t cmd,
  output logic     issue,
  output logic     credit_en,
  output logic     pend_clr
);

  localparam int WW = $clog2(EXIT_CYC + 1);
  localparam logic [WW-1:0] TRC_LOAD  = WW'(TRC - 1);
  localparam logic [WW-1:0] EXIT_LOAD = WW'(EXIT_CYC - 1);

  seq_state_t    state_q, state_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          wcnt_en;
  logic          wdone;

  assign wdone = (wcnt_q == '0);

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    wcnt_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sleep_req && banks_idle) begin
          state_d = ST_SENTER;
        end else if (pend_nz && ref_ack) begin
          state_d = ST_REF;
        end
      end
      ST_REF: begin
        state_d = ST_RWAIT;
        wcnt_d  = TRC_LOAD;
        wcnt_en = 1'b1;
      end
      ST_RWAIT: begin
        if (wdone) begin
          state_d = pend_nz ? ST_REF : ST_IDLE;
        end else begin
          wcnt_d  = wcnt_q - 1'b1;
          wcnt_en = 1'b1;
        end
      end
      ST_SENTER: begin
        state_d = ST_SR;
      end
      ST_SR: begin
        if (wake_req) begin
          state_d = ST_EXIT;
          wcnt_d  = EXIT_LOAD;
          wcnt_en = 1'b1;
        end
      end
      ST_EXIT: begin
        if (wdone) begin
          state_d = ST_IDLE;
        end else begin
          wcnt_d  = wcnt_q - 1'b1;
          wcnt_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
    end else if (wcnt_en) begin
      wcnt_q <= wcnt_d;
    end
  end

  always_comb begin
    ref_req   = (state_q == ST_IDLE) && pend_nz;
    busy      = (state_q == ST_REF) || (state_q == ST_RWAIT) || (state_q == ST_EXIT);
    in_sr     = (state_q == ST_SENTER) || (state_q == ST_SR);
    cke       = !in_sr;
    issue     = (state_q == ST_REF);
    pend_clr  = (state_q == ST_SENTER);
    credit_en = !in_sr && (state_q != ST_EXIT);
    unique case (state_q)
      ST_REF:    cmd = CMD_REFRESH;
      ST_SENTER: cmd = CMD_SR_ENTER;
      default:   cmd = CMD_NOP;
    endcase
  end

endmodule

// File: rtl/sdram_refresh_mgr.sv
module sdram_refresh_mgr
  import rfm_pkg::*;
#(
  parameter int INT_4K     = 1560,
  parameter int INT_8K     = 780,
  parameter bit ROWS_8K    = 1'b0,
  parameter int TRC_FAST   = 7,
  parameter int TRC_SLOW   = 8,
  parameter bit SLOW_GRADE = 1'b0,
  parameter int REG_LAT    = 1,
  parameter int MAX_PEND   = 8,
  parameter int PW         = $clog2(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_ack,
  input  logic          sleep_req,
  input  logic          banks_idle,
  input  logic          wake_req,
  output logic          ref_req,
  output logic          busy,
  output logic          cke,
  output logic [1:0]    mem_cmd,
  output logic          in_self_refresh,
  output logic [PW-1:0] pend_cnt
);

  localparam int TRC      = SLOW_GRADE ? TRC_SLOW : TRC_FAST;
  localparam int EXIT_CYC = TRC + REG_LAT + 2;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       tick;
  logic       credit_en;
  logic       issue;
  logic       pend_clr;
  logic       pend_nz;
  mem_cmd_t   cmd_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  rfm_interval_timer #(
    .INT_4K  (INT_4K),
    .INT_8K  (INT_8K),
    .ROWS_8K (ROWS_8K)
  ) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick)
  );

  rfm_pending_ctr #(
    .MAX_PEND (MAX_PEND),
    .PW       (PW)
  ) u_pend (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .inc     (tick && credit_en),
    .dec     (issue),
    .clr     (pend_clr),
    .count   (pend_cnt),
    .nonzero (pend_nz)
  );

  rfm_sequencer #(
    .TRC      (TRC),
    .EXIT_CYC (EXIT_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pend_nz    (pend_nz),
    .ref_ack    (ref_ack),
    .sleep_req  (sleep_req),
    .banks_idle (banks_idle),
    .wake_req   (wake_req),
    .ref_req    (ref_req),
    .busy       (busy),
    .cke        (cke),
    .in_sr      (in_self_refresh),
    .cmd        (cmd_w),
    .issue      (issue),
    .credit_en  (credit_en),
    .pend_clr   (pend_clr)
  );

  assign mem_cmd = cmd_w;

endmodule

// File: rtl/sdram_refresh_mgr_chk.sv
module sdram_refresh_mgr_chk #(
  parameter int MAX_PEND = 8,
  parameter int PW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ref_ack,
  input logic          sleep_req,
  input logic          banks_idle,
  input logic          ref_req,
  input logic          busy,
  input logic          cke,
  input logic [1:0]    mem_cmd,
  input logic          in_self_refresh,
  input logic [PW-1:0] pend_cnt
);

  AST_REQ_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !busy);  // R3

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_ack && !sleep_req) |=> ref_req);  // R3

  AST_REFRESH_THEN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 2'b01) |=> ((mem_cmd == 2'b00) && busy));  // R4

  AST_PEND_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PW'(MAX_PEND));  // R5

  AST_ENTRY_CKE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 2'b10) |-> (!cke && in_self_refresh));  // R8

  AST_ENTRY_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 2'b10) |-> ($past(sleep_req) && $past(banks_idle)));  // R8

  AST_CKE_LOW_ONLY_SR: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> in_self_refresh);  // R10

  AST_WAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (busy && (mem_cmd == 2'b00)));  // R11

endmodule

bind sdram_refresh_mgr sdram_refresh_mgr_chk #(
  .MAX_PEND (MAX_PEND),
  .PW       (PW)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ref_ack         (ref_ack),
  .sleep_req       (sleep_req),
  .banks_idle      (banks_idle),
  .ref_req         (ref_req),
  .busy            (busy),
  .cke             (cke),
  .mem_cmd         (mem_cmd),
  .in_self_refresh (in_self_refresh),
  .pend_cnt        (pend_cnt)
);

// File: tb/tb_sdram_refresh_mgr.sv
`timescale 1ns/1ps
module tb_sdram_refresh_mgr;

  localparam int INT_A    = 100;
  localparam int INT_B    = 50;
  localparam int TRC      = 8;
  localparam int EXIT_CYC = TRC + 3;
  localparam int PW       = 4;

  logic clk;
  logic rst_n;
  logic ref_ack, sleep_req, banks_idle, wake_req;
  logic ref_req, busy, cke, in_sr;
  logic [1:0] cmd;
  logic [PW-1:0] pend;

  logic ref_req_b, busy_b, cke_b, in_sr_b;
  logic [1:0] cmd_b;
  logic [PW-1:0] pend_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sdram_refresh_mgr #(
    .INT_4K(INT_A), .INT_8K(INT_B), .ROWS_8K(1'b0), .SLOW_GRADE(1'b1)
  ) dut (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .sleep_req(sleep_req),
    .banks_idle(banks_idle), .wake_req(wake_req), .ref_req(ref_req),
    .busy(busy), .cke(cke), .mem_cmd(cmd), .in_self_refresh(in_sr),
    .pend_cnt(pend)
  );

  sdram_refresh_mgr #(
    .INT_4K(INT_A), .INT_8K(INT_B), .ROWS_8K(1'b1), .SLOW_GRADE(1'b0)
  ) dut_b (
    .clk(clk), .rst_n(rst_n), .ref_ack(1'b0), .sleep_req(1'b0),
    .banks_idle(1'b0), .wake_req(1'b0), .ref_req(ref_req_b),
    .busy(busy_b), .cke(cke_b), .mem_cmd(cmd_b), .in_self_refresh(in_sr_b),
    .pend_cnt(pend_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 400 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(cke == 1'b1, "R1 cke", cke, 1);
    chk(busy == 1'b0 && ref_req == 1'b0, "R1 busy/ref_req", {busy, ref_req}, 0);
    chk(cmd == 2'b00, "R1 cmd", cmd, 0);
    chk(in_sr == 1'b0, "R1 in_self_refresh", in_sr, 0);
    chk(pend == '0, "R1 pend_cnt", pend, 0);
  endtask

  task automatic period_a(output int n);
    logic [PW-1:0] prev;
    prev = pend;
    n = 0;
    for (int i = 0; i < 1000 && pend == prev; i++) begin @(negedge clk); n++; end
    prev = pend;
    n = 0;
    for (int i = 0; i < 1000 && pend == prev; i++) begin @(negedge clk); n++; end
  endtask

  task automatic t_interval();
    logic [PW-1:0] prev;
    int n;
    prev = pend_b;
    for (int i = 0; i < 1000 && pend_b == prev; i++) @(negedge clk);
    prev = pend_b;
    n = 0;
    for (int i = 0; i < 1000 && pend_b == prev; i++) begin @(negedge clk); n++; end
    chk(n == INT_B, "R2 8k-row interval", n, INT_B);
    period_a(n);
    chk(n == INT_A, "R2 4k-row interval", n, INT_A);
    chk(ref_req == 1'b1, "R3 request raised", ref_req, 1);
    repeat (20) @(negedge clk);
    chk(ref_req == 1'b1, "R3 request held without ack", ref_req, 1);
  endtask

  task automatic t_saturate();
    repeat (1000) @(negedge clk);
    chk(pend == 4'd8, "R5 saturation", pend, 8);
    repeat (200) @(negedge clk);
    chk(pend == 4'd8, "R5 stays at cap", pend, 8);
  endtask

  task automatic t_drain();
    int count, since, bad;
    ref_ack = 1'b1;
    @(negedge clk);
    ref_ack = 1'b0;
    chk(cmd == 2'b01 && busy == 1'b1, "R4 REFRESH after ack", {cmd, busy}, 3);
    count = 1; since = 0; bad = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!busy) break;
      since++;
      if (cmd == 2'b01) begin
        if (since != TRC + 1) bad++;
        count++;
        since = 0;
      end
    end
    since++;
    chk(since == TRC + 1, "R4 row cycle after last REFRESH", since, TRC + 1);
    chk(count >= 8, "R6 credits drained by one grant", count, 8);
    chk(bad == 0, "R6 back-to-back spacing", bad, 0);
  endtask

  task automatic t_collide();
    logic [PW-1:0] prev;
    logic [PW-1:0] p;
    wait_idle();
    prev = pend;
    for (int i = 0; i < 300 && pend == prev; i++) @(negedge clk);
    p = pend;
    repeat (INT_A - 2) @(negedge clk);
    ref_ack = 1'b1;
    @(negedge clk);
    ref_ack = 1'b0;
    chk(cmd == 2'b01, "R7 REFRESH placed on credit edge", cmd, 1);
    @(negedge clk);
    chk(pend == p, "R7 credit and issue cancel", pend, p);
    @(negedge clk);
    wait_idle();
  endtask

  task automatic t_sleep_hold();
    int bad;
    wait_idle();
    banks_idle = 1'b0;
    sleep_req  = 1'b1;
    bad = 0;
    repeat (6) begin
      @(negedge clk);
      if (!cke || in_sr || cmd == 2'b10) bad++;
    end
    chk(bad == 0, "R8 sleep held while banks open", bad, 0);
    banks_idle = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk(cmd == 2'b10, "R8 entry command", cmd, 2);
    chk(cke == 1'b0 && in_sr == 1'b1, "R8 cke low with entry", {cke, in_sr}, 1);
    @(negedge clk);
    chk(cmd == 2'b00 && cke == 1'b0, "R10 NOP with cke low", {cmd, cke}, 0);
  endtask

  task automatic t_sr_hold();
    int bad;
    bad = 0;
    ref_ack   = 1'b1;
    sleep_req = 1'b1;
    repeat (250) begin
      @(negedge clk);
      if (cke || ref_req || busy || pend != '0 || cmd != 2'b00) bad++;
    end
    ref_ack   = 1'b0;
    sleep_req = 1'b0;
    chk(bad == 0, "R10 self-refresh holds", bad, 0);
  endtask

  task automatic t_wake();
    int n, bad;
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    chk(cke == 1'b1 && busy == 1'b1 && in_sr == 1'b0, "R11 cke raised, busy", {cke, busy, in_sr}, 6);
    n = 1; bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!busy) break;
      if (cmd != 2'b00) bad++;
      n++;
    end
    chk(n == EXIT_CYC && bad == 0, "R11 exit wait length", n, EXIT_CYC);
  endtask

  task automatic t_wake_ignored();
    int bad;
    bad = 0;
    wake_req = 1'b1;
    repeat (5) begin
      @(negedge clk);
      if (busy || !cke) bad++;
    end
    wake_req = 1'b0;
    chk(bad == 0, "R11 wake ignored when awake", bad, 0);
  endtask

  task automatic t_sleep_vs_ack();
    for (int i = 0; i < 300 && !ref_req; i++) @(negedge clk);
    chk(ref_req == 1'b1, "R9 request before race", ref_req, 1);
    sleep_req  = 1'b1;
    banks_idle = 1'b1;
    ref_ack    = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    ref_ack   = 1'b0;
    chk(cmd == 2'b10, "R9 entry wins over grant", cmd, 2);
    @(negedge clk);
    chk(pend == '0 && ref_req == 1'b0, "R9 credits cleared", pend, 0);
    t_wake();
  endtask

  initial begin
    ref_ack = 1'b0; sleep_req = 1'b0; banks_idle = 1'b1; wake_req = 1'b0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_interval();
    t_saturate();
    t_drain();
    t_collide();
    t_sleep_hold();
    t_sr_hold();
    t_wake();
    t_wake_ignored();
    t_sleep_vs_ack();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule